// File: doc/BRIEF.md
# Two-Step Microcoded Control Sequencer

This block is the control core of a protocol engine. It walks a byte-wide program store with a program counter that moves once per clock. Each instruction uses two consecutive counter steps. The first step latches the opcode byte from an even address into an opcode register. The second step reads the immediate byte from the next odd address and acts on the instruction. The counter therefore runs at twice the instruction rate. Three instruction classes are decoded. The first is a timed idle, which freezes the counter for a number of instruction periods. The second is a jump, which reloads the counter from the immediate byte. Every other opcode is a generic operation, whose opcode and immediate byte are offered to the surrounding datapath on a valid/ready output.

An external reconfiguration timeout can interrupt the sequencer at any point. It sends the counter back to address 0 and raises a sticky status flag, which stays set until a clear input is pulsed. The program store is a writable array. It is loaded through a simple write port, normally while reset is held.

The operation output follows valid/ready rules. While `exec_valid` is high and `exec_ready` is low, the sequencer waits: the counter, `exec_op` and `exec_data` all hold. A transfer happens on a rising edge where both signals are high. `exec_valid` never depends on `exec_ready`. The one exception to holding an offer is the timeout: it withdraws an offer in the same cycle it is asserted, and no transfer happens in that cycle.

Top module: `microseq_core`

## Requirements
- R1: While reset is asserted, and right after it, `seq_pc` is 0, `recon_flag` is 0 and `exec_valid` is 0.
- R2: With no stall, an instruction takes two clocks. The opcode is read at the even address, then the immediate at the odd address. `seq_pc` goes up by one on each of these two clocks, and `exec_valid` is only ever high while `seq_pc` is odd.
- R3: An opcode that is neither 8'h00 nor in 8'h10–8'h1F is a generic operation. In its second clock, `exec_valid` rises with `exec_op` equal to the opcode and `exec_data` equal to the immediate. Each such instruction is transferred exactly once, in program order.
- R4: While `exec_valid` is high and `exec_ready` is low, `seq_pc`, `exec_op` and `exec_data` hold. The clock after the transfer, `seq_pc` points to the next even address.
- R5: Opcode 8'h00 is a timed idle with immediate N ≥ 1. After its second clock, `seq_pc` holds the next instruction's address for 2·N clocks, and only then is that instruction fetched.
- R6: A timed idle with immediate 0 holds for exactly one instruction period, which is 2 clocks.
- R7: An opcode 8'h1X is a jump. After its second clock, `seq_pc` equals {opcode bit 0, immediate, 1'b0}: the immediate times 2, with opcode bit 0 as address bit 9.
- R8: If `tmo_pulse` is high at a rising edge, then after that edge `seq_pc` is 0 and `recon_flag` is 1. This overrides a timed idle, a jump or a pending operation. While `tmo_pulse` is high, `exec_valid` is 0.
- R9: `recon_flag` stays set until `flag_clr` is high at an edge. If `tmo_pulse` and `flag_clr` are high together, the flag ends up set.
- R10: A write with `prog_we` high stores `prog_data` at `prog_addr`, and later fetches from that address return the stored byte. An address at or beyond the store depth reads as 8'h00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one program-counter step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 10 | Program store write address |
| prog_data | input | 8 | Program store write byte |
| tmo_pulse | input | 1 | Reconfiguration timeout interrupt |
| flag_clr | input | 1 | Clears the reconfiguration status flag |
| exec_ready | input | 1 | Datapath accepts the offered operation |
| exec_valid | output | 1 | A generic operation is offered |
| exec_op | output | 8 | Opcode of the offered operation |
| exec_data | output | 8 | Immediate byte of the offered operation |
| seq_pc | output | 10 | Current program counter |
| recon_flag | output | 1 | Sticky reconfiguration status |

## Verification
Counting from the first rising edge after reset is released, or after a timeout, the counter value of every instruction is due on a known edge. The opcode fetch shows up after edge 1. The operation offer, jump target or idle start shows up after edge 2. An idle of N releases the fetch 2·N edges after that. A timeout shows up one edge after the clock in which it was driven. The bench drives inputs on falling edges and compares `seq_pc` and `recon_flag` on the falling edge that follows the edge where each result is due. A scoreboard queue takes the expected operations. A monitor samples the handshake a quarter period after each falling edge, which means one transfer is counted per rising edge where valid and ready are both high.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  typedef enum logic [1:0] {K_NOP, K_JUMP, K_EXEC} op_kind_t;
  typedef enum logic [1:0] {S_OP, S_IM, S_WAIT} seq_state_t;
  localparam logic [7:0] OPC_IDLE    = 8'h00;
  localparam logic [3:0] OPC_JUMP_HI = 4'h1;
endpackage

// File: rtl/microseq_rom.sv
module microseq_rom #(
  parameter int DEPTH = 554,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW:0] DEPTH_L = DEPTH[AW:0];

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < DEPTH_L)) mem[waddr] <= wdata;
  end

  always_comb begin
    if ({1'b0, raddr} < DEPTH_L) rdata = mem[raddr];
    else                         rdata = '0;
  end
endmodule

// File: rtl/microseq_decode.sv
module microseq_decode
  import microseq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic [DW-1:0] op,
  input  logic [DW-1:0] imm,
  output op_kind_t      kind,
  output logic [AW-1:0] jmp_tgt
);
  always_comb begin
    if (op == OPC_IDLE)               kind = K_NOP;
    else if (op[7:4] == OPC_JUMP_HI)  kind = K_JUMP;
    else                              kind = K_EXEC;
  end

  assign jmp_tgt = AW'({op[0], imm, 1'b0});
endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import microseq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmo,
  input  logic          clr,
  input  logic [DW-1:0] rdata,
  input  op_kind_t      kind,
  input  logic [AW-1:0] jmp_tgt,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] op,
  output logic          flag
);
  localparam int CW = DW + 1;

  seq_state_t    st_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] op_q;
  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic [DW-1:0] idle_len;

  assign idle_len = (rdata == '0) ? DW'(1) : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_OP;
      pc_q  <= '0;
      op_q  <= '0;
      cnt_q <= '0;
    end else if (tmo) begin
      st_q  <= S_OP;
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_OP: begin
          op_q <= rdata;
          pc_q <= pc_q + 1'b1;
          st_q <= S_IM;
        end
        S_IM: begin
          case (kind)
            K_NOP: begin
              pc_q  <= pc_q + 1'b1;
              cnt_q <= {idle_len, 1'b0} - 1'b1;
              st_q  <= S_WAIT;
            end
            K_JUMP: begin
              pc_q <= jmp_tgt;
              st_q <= S_OP;
            end
            default: begin
              if (ready) begin
                pc_q <= pc_q + 1'b1;
                st_q <= S_OP;
              end
            end
          endcase
        end
        S_WAIT: begin
          if (cnt_q == '0) st_q <= S_OP;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= S_OP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (tmo) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign valid = (st_q == S_IM) && (kind == K_EXEC) && !tmo;
  assign pc    = pc_q;
  assign op    = op_q;
  assign flag  = flag_q;
endmodule

// File: rtl/microseq_core.sv
module microseq_core
  import microseq_pkg::*;
#(
  parameter int DEPTH = 554,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          tmo_pulse,
  input  logic          flag_clr,
  input  logic          exec_ready,
  output logic          exec_valid,
  output logic [DW-1:0] exec_op,
  output logic [DW-1:0] exec_data,
  output logic [AW-1:0] seq_pc,
  output logic          recon_flag
);
  logic [DW-1:0] rd_byte;
  logic [DW-1:0] op_reg;
  logic [AW-1:0] jmp_tgt;
  op_kind_t      kind;

  microseq_rom #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_rom (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (seq_pc),
    .rdata (rd_byte)
  );

  microseq_decode #(.AW(AW), .DW(DW)) u_dec (
    .op      (op_reg),
    .imm     (rd_byte),
    .kind    (kind),
    .jmp_tgt (jmp_tgt)
  );

  microseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmo     (tmo_pulse),
    .clr     (flag_clr),
    .rdata   (rd_byte),
    .kind    (kind),
    .jmp_tgt (jmp_tgt),
    .ready   (exec_ready),
    .valid   (exec_valid),
    .pc      (seq_pc),
    .op      (op_reg),
    .flag    (recon_flag)
  );

  assign exec_op   = op_reg;
  assign exec_data = rd_byte;
endmodule

// File: rtl/microseq_chk.sv
module microseq_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmo_pulse,
  input logic          flag_clr,
  input logic          exec_ready,
  input logic          exec_valid,
  input logic [DW-1:0] exec_op,
  input logic [DW-1:0] exec_data,
  input logic [AW-1:0] seq_pc,
  input logic          recon_flag
);
  AST_RECON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> (seq_pc == '0) && recon_flag); // R8

  AST_OFFER_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> seq_pc[0]); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_ready && !tmo_pulse) |=>
      ($stable(seq_pc) && $stable(exec_op) && $stable(exec_data))); // R4

  AST_XFER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_ready) |=> (seq_pc == AW'($past(seq_pc) + 1'b1))); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_flag && !flag_clr) |=> recon_flag); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tmo_pulse) |=> !recon_flag); // R9

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!recon_flag && !tmo_pulse) |=> !recon_flag); // R9
endmodule

bind microseq_core microseq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_microseq_core.sv
module tb_microseq_core;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic          tmo_pulse = 1'b0;
  logic          flag_clr = 1'b0;
  logic          exec_ready = 1'b1;
  logic          exec_valid;
  logic [DW-1:0] exec_op;
  logic [DW-1:0] exec_data;
  logic [AW-1:0] seq_pc;
  logic          recon_flag;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;

  microseq_core dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    tick(1);
    prog_we = 1'b0;
  endtask

  task automatic push_exp(input logic [7:0] op, input logic [7:0] imm);
    exp_q.push_back({op, imm});
  endtask

  task automatic push_run();
    push_exp(8'h20, 8'hA1); push_exp(8'h33, 8'h5C); push_exp(8'h7F, 8'h42);
  endtask

  // monitor: one transfer per rising edge with valid and ready both high
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && exec_valid && exec_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R3 unexpected transfer actual=%0h expected=none", {exec_op, exec_data});
        end else begin
          check("R3 operation order", {16'h0, exec_op, exec_data}, {16'h0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(1);
    // program (R10: all behaviour below comes from these writes)
    wr(10'd0,   8'h20); wr(10'd1,   8'hA1);
    wr(10'd2,   8'h00); wr(10'd3,   8'h03);
    wr(10'd4,   8'h11); wr(10'd5,   8'h05);
    wr(10'd522, 8'h33); wr(10'd523, 8'h5C);
    wr(10'd524, 8'h00); wr(10'd525, 8'h00);
    wr(10'd526, 8'h10); wr(10'd527, 8'h08);
    wr(10'd16,  8'h7F); wr(10'd17,  8'h42);
    wr(10'd18,  8'h10); wr(10'd19,  8'h09);
    check("R1 pc", seq_pc, 0);
    check("R1 flag", recon_flag, 0);
    check("R1 valid", exec_valid, 0);

    // scenario 1: free run
    push_run();
    rst_n = 1'b1;
    tick(1);  check("R2 pc after opcode", seq_pc, 1);
              check("R3 offer", exec_valid, 1);
    tick(1);  check("R2 pc next even", seq_pc, 2);
    tick(2);  check("R5 idle start", seq_pc, 4);
    tick(5);  check("R5 idle held", seq_pc, 4);
    tick(1);  check("R5 idle last", seq_pc, 4);
    tick(1);  check("R5 fetch after 6", seq_pc, 5);
    tick(1);  check("R7 R10 jump high", seq_pc, 522);
    tick(4);  check("R6 idle0 start", seq_pc, 526);
    tick(2);  check("R6 idle0 held", seq_pc, 526);
    tick(1);  check("R6 fetch after 2", seq_pc, 527);
    tick(1);  check("R7 jump low", seq_pc, 16);
    tick(4);  check("R7 self loop", seq_pc, 18);
    tick(2);  check("R7 self loop again", seq_pc, 18);
    check("R3 all transferred", exp_q.size(), 0);

    // scenario 2: back-pressure
    rst_n = 1'b0; exec_ready = 1'b0;
    tick(1);
    push_run();
    rst_n = 1'b1;
    tick(1);  check("R4 offer pc", seq_pc, 1);
    tick(3);  check("R4 held pc", seq_pc, 1);
              check("R4 held valid", exec_valid, 1);
              check("R4 held data", exec_data, 8'hA1);
    exec_ready = 1'b1;
    tick(1);  check("R4 pc after transfer", seq_pc, 2);
    tick(30); check("R4 single transfer each", exp_q.size(), 0);

    // scenario 3: timeout and status flag
    push_exp(8'h20, 8'hA1);
    tmo_pulse = 1'b1; tick(1); tmo_pulse = 1'b0;
    check("R8 pc cleared", seq_pc, 0);
    check("R8 flag set", recon_flag, 1);
    tick(6);  check("R5 in idle", seq_pc, 4);
    tmo_pulse = 1'b1; tick(1); tmo_pulse = 1'b0;
    check("R8 overrides idle", seq_pc, 0);
    push_exp(8'h20, 8'hA1);
    tick(1);  check("R8 offer before", exec_valid, 1);
    tmo_pulse = 1'b1; #1;
    check("R8 offer withdrawn", exec_valid, 0);
    tick(1); tmo_pulse = 1'b0;
    check("R8 overrides offer", seq_pc, 0);
    tick(3);  check("R9 flag sticky", recon_flag, 1);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    check("R9 flag cleared", recon_flag, 0);
    check("R8 one transfer per run", exp_q.size(), 0);
    push_run();
    tmo_pulse = 1'b1; flag_clr = 1'b1; tick(1);
    tmo_pulse = 1'b0; flag_clr = 1'b0;
    check("R9 set wins", recon_flag, 1);
    check("R8 pc cleared again", seq_pc, 0);
    tick(40); check("R3 full rerun", exp_q.size(), 0);
              check("R7 loop after rerun", seq_pc[AW-1:1], 9);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule